// File: doc/BRIEF.md
# Endpoint-0 Control Transfer Stage Manager

This block follows a control transfer on endpoint 0 of a device controller. A packet engine hands it decoded token events (SETUP, IN, OUT) and, with each SETUP, the eight setup bytes. From those bytes it works out the transfer type: control read, control write with data, or control write without data. It then walks through the SETUP, DATA and STATUS stages and returns to IDLE. For each token it picks the handshake the packet engine should send back.

Moving from one stage to the next needs two things: the host must send the token for that stage, and the CPU must release the current stage with a control write. If the host is early, it gets NAK and retries later. A token in the wrong direction gets STALL and parks the block in IDLE. A SETUP token always wins: it aborts whatever transfer is running, latches the new bytes and raises a setup interrupt. The CPU clears that interrupt by writing one to a clear bit.

Top module: `ep0_stage_ctrl`

## Requirements
- R1: The transfer type is taken from the latched setup bytes. Bit 7 of byte 0 (data bit 7) set means device-to-host. The length is bytes 6 and 7, little-endian (data bits 63:48). The type is 2 (no data) when the length is zero, 0 (read) when the direction bit is set, and 1 (write) otherwise.
- R2: A SETUP token (pid 0), arriving in any stage, moves the stage to SETUP (code 1), gets ACK, and latches the eight setup bytes on `setup_data_o`.
- R3: Every SETUP sets `setup_irq_o`. It stays set until a CPU write with bit 1 set clears it. If a SETUP and a clear arrive in the same cycle, the SETUP wins. A SETUP that arrives while the flag is already set keeps it set and overwrites the latched bytes.
- R4: In SETUP stage, a token of the next stage's direction that arrives before the CPU releases the stage gets NAK, and the stage does not change. The next stage's direction is the data direction, or IN when there is no data stage.
- R5: A CPU write with bit 0 set moves SETUP to DATA (code 2), or to STATUS (code 3) for a no-data transfer, and moves DATA to STATUS. It has no effect in IDLE or STATUS. If a token forces a stage change in the same cycle, the token's change wins.
- R6: In DATA stage, a token in the data direction gets ACK. A token in the status direction gets NAK. Neither changes the stage.
- R7: In STATUS stage, a token in the status direction gets ACK and the stage returns to IDLE (code 0). The status direction is the opposite of the data direction; for a no-data transfer it is IN.
- R8: An IN (pid 1) or OUT (pid 2) token whose direction does not match the current stage gets STALL and the stage goes to IDLE. In IDLE, every IN or OUT gets STALL.
- R9: `hs_valid_o` is high exactly in the cycle after a token with pid 0, 1 or 2. Pid 3 gets no handshake and changes nothing. Handshake codes are ACK=1, NAK=2, STALL=3.
- R10: After reset the stage is IDLE, `setup_irq_o` and `hs_valid_o` are low, and `setup_data_o` and `xfer_type_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tok_valid_i | input | 1 | A token event is present this cycle |
| tok_pid_i | input | 2 | Token kind: 0 SETUP, 1 IN, 2 OUT, 3 reserved |
| setup_data_i | input | 64 | Setup bytes; byte n is bits 8n+7:8n; sampled with a SETUP token |
| cpu_wr_i | input | 1 | CPU write to the stage-control register |
| cpu_wdata_i | input | 2 | Bit 0 releases the current stage; bit 1 clears the setup interrupt |
| stage_o | output | 2 | Current stage: 0 IDLE, 1 SETUP, 2 DATA, 3 STATUS |
| xfer_type_o | output | 2 | Transfer type: 0 read, 1 write, 2 no data |
| hs_valid_o | output | 1 | Handshake decision valid |
| hs_code_o | output | 2 | Handshake: 1 ACK, 2 NAK, 3 STALL |
| setup_irq_o | output | 1 | Setup interrupt flag |
| setup_data_o | output | 64 | Latched setup bytes |

## Verification
A wrong stage register shows up at the ports on the next host token. That token gets the wrong handshake: an ACK where NAK was due, or a STALL that drops the transfer to IDLE. `stage_o` shows the same fault one cycle after the edge that caused it. A wrongly classified transfer shows up as the wrong direction being accepted in DATA or STATUS. A lost interrupt set, or a clear that should have been overridden, shows on `setup_irq_o` one cycle after the SETUP. The bench compares every output in every cycle, so any of these faults is reported in the cycle it first appears.

// File: rtl/ep0_stage_pkg.sv
package ep0_stage_pkg;
  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_SETUP  = 2'd1,
    STG_DATA   = 2'd2,
    STG_STATUS = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    XF_READ   = 2'd0,
    XF_WRITE  = 2'd1,
    XF_NODATA = 2'd2
  } xfer_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  localparam logic [1:0] PID_SETUP = 2'd0;
  localparam logic [1:0] PID_IN    = 2'd1;
  localparam logic [1:0] PID_OUT   = 2'd2;
  localparam logic [1:0] PID_RSVD  = 2'd3;

  function automatic logic [1:0] data_pid(input xfer_e t);
    case (t)
      XF_READ:  data_pid = PID_IN;
      XF_WRITE: data_pid = PID_OUT;
      default:  data_pid = PID_RSVD;
    endcase
  endfunction

  function automatic logic [1:0] status_pid(input xfer_e t);
    status_pid = (t == XF_READ) ? PID_OUT : PID_IN;
  endfunction
endpackage

// File: rtl/ep0_setup_classify.sv
module ep0_setup_classify
  import ep0_stage_pkg::*;
#(
  parameter int NBYTES  = 8,
  parameter int DIR_BIT = 7,
  parameter int LEN_IDX = 6
) (
  input  logic [NBYTES*8-1:0] bytes_i,
  output xfer_e               type_o
);
  localparam int LEN_W = 16;

  logic [LEN_W-1:0] len;
  logic             to_host;

  assign len     = {bytes_i[(LEN_IDX+1)*8 +: 8], bytes_i[LEN_IDX*8 +: 8]};
  assign to_host = bytes_i[DIR_BIT];

  always_comb begin
    if (len == '0)    type_o = XF_NODATA;
    else if (to_host) type_o = XF_READ;
    else              type_o = XF_WRITE;
  end
endmodule

// File: rtl/ep0_setup_latch.sv
module ep0_setup_latch
  import ep0_stage_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic [NBYTES*8-1:0] bytes_i,
  input  xfer_e               type_i,
  input  logic                clr_i,
  output logic [NBYTES*8-1:0] bytes_o,
  output xfer_e               type_o,
  output logic                irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bytes_o <= '0;
      type_o  <= XF_READ;
      irq_o   <= 1'b0;
    end else begin
      if (capture_i) begin
        bytes_o <= bytes_i;
        type_o  <= type_i;
      end
      // a new setup beats a same-cycle clear
      if (capture_i)  irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
    end
  end

  p_irq_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> irq_o);
  p_irq_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  p_bytes_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(bytes_o));
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_stage_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tok_valid_i,
  input  logic [1:0] tok_pid_i,
  input  logic       adv_i,
  input  xfer_e      type_i,
  output stage_e     stage_o,
  output logic       hs_valid_o,
  output hs_e        hs_o
);
  stage_e     stage_d;
  hs_e        hs_d;
  logic       hsv_d;
  logic       tok;
  logic       forced;
  logic [1:0] dpid;
  logic [1:0] spid;
  logic [1:0] next_pid;

  assign tok      = tok_valid_i && (tok_pid_i != PID_RSVD);
  assign dpid     = data_pid(type_i);
  assign spid     = status_pid(type_i);
  assign next_pid = (type_i == XF_NODATA) ? spid : dpid;

  always_comb begin
    stage_d = stage_o;
    hs_d    = HS_NONE;
    hsv_d   = 1'b0;
    forced  = 1'b0;
    if (tok) begin
      hsv_d = 1'b1;
      if (tok_pid_i == PID_SETUP) begin
        stage_d = STG_SETUP;
        hs_d    = HS_ACK;
        forced  = 1'b1;
      end else begin
        unique case (stage_o)
          STG_SETUP: begin
            if (tok_pid_i == next_pid) hs_d = HS_NAK;
            else begin
              hs_d = HS_STALL; stage_d = STG_IDLE; forced = 1'b1;
            end
          end
          STG_DATA: begin
            if (tok_pid_i == dpid)      hs_d = HS_ACK;
            else if (tok_pid_i == spid) hs_d = HS_NAK;
            else begin
              hs_d = HS_STALL; stage_d = STG_IDLE; forced = 1'b1;
            end
          end
          STG_STATUS: begin
            hs_d    = (tok_pid_i == spid) ? HS_ACK : HS_STALL;
            stage_d = STG_IDLE;
            forced  = 1'b1;
          end
          default: begin
            hs_d = HS_STALL; stage_d = STG_IDLE; forced = 1'b1;
          end
        endcase
      end
    end
    // CPU release only when no token forced a change
    if (adv_i && !forced) begin
      if (stage_o == STG_SETUP)
        stage_d = (type_i == XF_NODATA) ? STG_STATUS : STG_DATA;
      else if (stage_o == STG_DATA)
        stage_d = STG_STATUS;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_o    <= STG_IDLE;
      hs_valid_o <= 1'b0;
      hs_o       <= HS_NONE;
    end else begin
      stage_o    <= stage_d;
      hs_valid_o <= hsv_d;
      hs_o       <= hs_d;
    end
  end

  p_setup_enters_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_pid_i == PID_SETUP) |=> (stage_o == STG_SETUP && hs_o == HS_ACK));
  p_nak_keeps_stage_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_pid_i != PID_SETUP && tok_pid_i != PID_RSVD && !adv_i
     && stage_o == STG_SETUP) |=> (hs_o != HS_ACK && stage_o != STG_DATA));
  p_status_ack_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && tok_pid_i != PID_SETUP && tok_pid_i != PID_RSVD
     && stage_o == STG_STATUS) |=> stage_o == STG_IDLE);
  p_stall_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && hs_o == HS_STALL) |-> stage_o == STG_IDLE);
  p_hs_follows_tok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o == $past(tok_valid_i && tok_pid_i != PID_RSVD));
  p_hs_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> hs_o != HS_NONE);
endmodule

// File: rtl/ep0_stage_ctrl.sv
module ep0_stage_ctrl
  import ep0_stage_pkg::*;
#(
  parameter int NBYTES  = 8,
  parameter int DIR_BIT = 7,
  parameter int LEN_IDX = 6,
  parameter int CTRL_W  = 2,
  parameter int ADV_BIT = 0,
  parameter int CLR_BIT = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tok_valid_i,
  input  logic [1:0]          tok_pid_i,
  input  logic [NBYTES*8-1:0] setup_data_i,
  input  logic                cpu_wr_i,
  input  logic [CTRL_W-1:0]   cpu_wdata_i,
  output logic [1:0]          stage_o,
  output logic [1:0]          xfer_type_o,
  output logic                hs_valid_o,
  output logic [1:0]          hs_code_o,
  output logic                setup_irq_o,
  output logic [NBYTES*8-1:0] setup_data_o
);
  xfer_e  new_type;
  xfer_e  cur_type;
  stage_e stage;
  hs_e    hs;
  logic   capture;
  logic   adv;
  logic   clr;

  assign capture = tok_valid_i && (tok_pid_i == PID_SETUP);
  assign adv     = cpu_wr_i && cpu_wdata_i[ADV_BIT];
  assign clr     = cpu_wr_i && cpu_wdata_i[CLR_BIT];

  ep0_setup_classify #(.NBYTES(NBYTES), .DIR_BIT(DIR_BIT), .LEN_IDX(LEN_IDX)) u_cls (
    .bytes_i(setup_data_i),
    .type_o (new_type)
  );

  ep0_setup_latch #(.NBYTES(NBYTES)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .bytes_i  (setup_data_i),
    .type_i   (new_type),
    .clr_i    (clr),
    .bytes_o  (setup_data_o),
    .type_o   (cur_type),
    .irq_o    (setup_irq_o)
  );

  ep0_stage_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tok_valid_i(tok_valid_i),
    .tok_pid_i  (tok_pid_i),
    .adv_i      (adv),
    .type_i     (cur_type),
    .stage_o    (stage),
    .hs_valid_o (hs_valid_o),
    .hs_o       (hs)
  );

  assign stage_o     = stage;
  assign hs_code_o   = hs;
  assign xfer_type_o = cur_type;

  p_type_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_type_o != 2'd3);
  p_nodata_skips_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_type_o == XF_NODATA && !capture) |=> stage_o != STG_DATA);
endmodule

// File: tb/ep0_stage_ctrl_tb.sv
module ep0_stage_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tok_valid = 1'b0;
  logic [1:0]  tok_pid = 2'd0;
  logic [63:0] sdata = '0;
  logic        cpu_wr = 1'b0;
  logic [1:0]  cpu_wdata = 2'd0;
  logic [1:0]  stage, xtype, hs_code;
  logic        hs_valid, irq;
  logic [63:0] sdata_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0]  m_stage = 0, m_type = 0, m_hs = 0;
  logic        m_irq = 0, m_hsv = 0;
  logic [63:0] m_bytes = '0;

  always #5 clk = ~clk;

  ep0_stage_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tok_valid_i(tok_valid), .tok_pid_i(tok_pid),
    .setup_data_i(sdata), .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata),
    .stage_o(stage), .xfer_type_o(xtype), .hs_valid_o(hs_valid), .hs_code_o(hs_code),
    .setup_irq_o(irq), .setup_data_o(sdata_o)
  );

  function automatic logic [1:0] classify(input logic [63:0] d);
    if (d[63:48] == 16'd0) return 2'd2;
    return d[7] ? 2'd0 : 2'd1;
  endfunction

  function automatic logic [1:0] dpid(input logic [1:0] t);
    return (t == 2'd0) ? 2'd1 : (t == 2'd1) ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [1:0] spid(input logic [1:0] t);
    return (t == 2'd0) ? 2'd2 : 2'd1;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "stage", stage, m_stage);
    chk(tag, "xfer_type", xtype, m_type);
    chk(tag, "hs_valid", hs_valid, m_hsv);
    if (m_hsv) chk(tag, "hs_code", hs_code, m_hs);
    chk(tag, "irq", irq, m_irq);
    chk(tag, "setup_data", sdata_o, m_bytes);
  endtask

  task automatic cyc(input logic tv, input logic [1:0] pid, input logic [63:0] d,
                     input logic cw, input logic [1:0] cd, input string tag);
    logic [1:0] ns, nh;
    logic nv, forced;
    tok_valid = tv; tok_pid = pid; sdata = d; cpu_wr = cw; cpu_wdata = cd;
    ns = m_stage; nh = 0; nv = 0; forced = 0;
    if (tv && pid != 2'd3) begin
      nv = 1;
      if (pid == 2'd0) begin ns = 1; nh = 1; forced = 1; end
      else begin
        case (m_stage)
          2'd1: if (pid == ((m_type == 2) ? spid(m_type) : dpid(m_type))) nh = 2;
                else begin nh = 3; ns = 0; forced = 1; end
          2'd2: if (pid == dpid(m_type)) nh = 1;
                else if (pid == spid(m_type)) nh = 2;
                else begin nh = 3; ns = 0; forced = 1; end
          2'd3: begin nh = (pid == spid(m_type)) ? 2'd1 : 2'd3; ns = 0; forced = 1; end
          default: begin nh = 3; ns = 0; forced = 1; end
        endcase
      end
    end
    if (cw && cd[0] && !forced) begin
      if (m_stage == 1) ns = (m_type == 2) ? 2'd3 : 2'd2;
      else if (m_stage == 2) ns = 3;
    end
    @(posedge clk);
    @(negedge clk);
    if (tv && pid == 2'd0) begin m_bytes = d; m_type = classify(d); end
    if (tv && pid == 2'd0) m_irq = 1;
    else if (cw && cd[1]) m_irq = 0;
    m_stage = ns; m_hs = nh; m_hsv = nv;
    tok_valid = 0; cpu_wr = 0;
    compare(tag);
  endtask

  function automatic logic [63:0] mk(input bit to_host, input logic [15:0] len);
    logic [63:0] d;
    d = {$urandom, $urandom};
    d[7] = to_host;
    d[63:48] = len;
    return d;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (2) @(negedge clk);
    compare("R10 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R10 after reset");

    // read transfer
    cyc(1, 0, mk(1, 16'h0040), 0, 0, "R2 R1 read setup");
    chk("R1", "read type", xtype, 2'd0);
    cyc(1, 1, '0, 0, 0, "R4 early IN nak");
    chk("R4", "nak code", hs_code, 2'd2);
    cyc(0, 0, '0, 1, 2'b01, "R5 release to data");
    chk("R5", "data stage", stage, 2'd2);
    cyc(1, 1, '0, 0, 0, "R6 data IN ack");
    cyc(1, 2, '0, 0, 0, "R6 status OUT nak");
    cyc(0, 0, '0, 1, 2'b01, "R5 release to status");
    cyc(1, 2, '0, 0, 0, "R7 status ack");
    chk("R7", "idle", stage, 2'd0);
    cyc(1, 1, '0, 0, 0, "R8 idle stall");
    chk("R8", "stall code", hs_code, 2'd3);
    cyc(0, 0, '0, 1, 2'b01, "R5 adv ignored in idle");
    cyc(1, 3, '0, 0, 0, "R9 reserved pid");
    cyc(0, 0, '0, 1, 2'b10, "R3 irq clear");
    // write transfer
    cyc(1, 0, mk(0, 16'h0008), 0, 0, "R1 write setup");
    cyc(0, 0, '0, 1, 2'b01, "R5 write data");
    cyc(1, 2, '0, 0, 0, "R6 write OUT ack");
    cyc(1, 1, '0, 1, 2'b01, "R6 R5 nak plus release");
    cyc(1, 1, '0, 0, 0, "R7 write status IN ack");
    // no-data transfer, setup overwrites while irq set
    cyc(1, 0, mk(1, 16'h0000), 0, 0, "R1 R3 nodata setup");
    cyc(0, 0, '0, 1, 2'b01, "R5 nodata to status");
    chk("R5", "status stage", stage, 2'd3);
    cyc(1, 2, '0, 0, 0, "R8 mismatch stall");
    // setup aborts data stage; set beats clear
    cyc(1, 0, mk(0, 16'h0100), 0, 0, "R2 setup");
    cyc(0, 0, '0, 1, 2'b01, "R5 to data");
    cyc(1, 0, mk(1, 16'h0002), 1, 2'b11, "R2 R3 setup aborts, set beats clear");
    cyc(1, 2, '0, 0, 0, "R8 wrong dir in setup stall");
    cyc(1, 1, '0, 0, 0, "R8 idle stall again");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic tv, cw;
      logic [1:0] pid, cd;
      logic [63:0] d;
      r = $urandom_range(0, 99);
      tv = (r < 90);
      pid = (r < 15) ? 2'd0 : (r < 50) ? 2'd1 : (r < 85) ? 2'd2 : 2'd3;
      d = mk($urandom_range(0, 1) == 1, ($urandom_range(0, 2) == 0) ? 16'd0 : 16'($urandom));
      cw = ($urandom_range(0, 99) < 30);
      cd = {($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1))};
      cyc(tv, pid, d, cw, cd, "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    finish_run();
  end
endmodule